// File: doc/BRIEF.md
# Memory Protection Access Checker

This block decides, for one memory access, whether it may proceed or must fault. It takes the physical byte address, the kind of access (read, write or instruction fetch), the current privilege level with the modify-privilege controls, and a flat table of protection regions. Each region has a configuration byte and an address register. The block finds the lowest-numbered active region that covers the address and combines that region's permission bits, its lock bit and the effective privilege into an allow flag and a fault code. The fault code names the access kind, so a trap unit downstream can raise a load, store or fetch access fault.

The region table is driven by the surrounding control logic. That logic also enforces write protection of locked entries. The checker only reads the table. A parameter adds one register stage after the combinational decision for timing closure. Without it, the result follows the inputs in the same cycle.

Top module: `mem_guard_checker`

## Requirements
- R1: When no region has an active mode (configuration bits 4:3 all zero in every region), every access is allowed with fault code 0.
- R2: When several active regions cover the address, only the lowest-numbered one decides the result.
- R3: Mode 1 (top of range) covers byte addresses from four times the previous region's address register up to, but not including, four times its own address register. Region 0 uses zero as its lower bound.
- R4: Mode 2 covers the four bytes at four times the address register. Mode 3 covers a naturally aligned block of 2^(t+3) bytes, where t is the number of trailing ones in the address register.
- R5: For a non-machine effective privilege, a covering region allows the access only if the matching permission bit is set: bit 0 for read, bit 1 for write, bit 2 for fetch.
- R6: For machine effective privilege (privilege code 3), a covering region whose lock bit (bit 7) is clear allows the access whatever its permission bits say.
- R7: For machine effective privilege, a covering region whose lock bit is set applies its permission bits exactly as R5 does.
- R8: When at least one region is active and none covers the address, machine effective privilege is allowed and privilege codes 0 and 1 fault.
- R9: With the modify-privilege enable set, reads and writes use the previous-privilege input as their effective privilege. Fetches always use the current privilege.
- R10: Access kind is coded 0 read, 1 write, 2 fetch (3 behaves as fetch). The fault code is 0 when allowed, and otherwise 1 for read, 2 for write and 3 for fetch.
- R11: With the output register enabled, the response valid, allow and fault code appear one clock after the request. Reset clears all three to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Physical byte address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mprv_en | input | 1 | Modify-privilege enable for reads and writes |
| mpp_priv | input | 2 | Previous privilege used when mprv_en is set |
| region_cfg | input | 8*N_REGIONS | Configuration bytes, region i at bits 8i+7..8i |
| region_addr | input | (ADDR_W-2)*N_REGIONS | Word address registers, region i at slice i |
| rsp_valid | output | 1 | Response valid |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 2 | Fault code per R10 |

## Verification
On every cycle, the assertions check that the chosen region really matches and that no lower-numbered region also matches. They also check the idle-table pass, the unlocked machine-mode pass, the miss fault for lower privileges, a zero fault code on every allowed access, and the one-cycle lag of the response valid. The range arithmetic cannot be seen by a per-cycle property. This covers the top-of-range bounds, the inclusive lower and exclusive upper edges, and the NAPOT sizes taken from trailing ones. The effect of setting a lock bit, and the switch of effective privilege for reads and writes but not fetches, are also outside their reach. Only the bench's directed scenarios and its reference model, compared on every clock, can show these.

// File: rtl/mgc_pkg.sv
package mgc_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_TOR   = 2'd1,
      MODE_NA4   = 2'd2,
      MODE_NAPOT = 2'd3
   } match_mode_e;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_EXEC  = 2'd2,
      KIND_RSVD  = 2'd3
   } access_kind_e;

   localparam logic [1:0] PRIV_MACHINE = 2'd3;

   // bit 7 lock, 6:5 spare, 4:3 mode, 2 fetch, 1 write, 0 read
   typedef struct packed {
      logic        locked;
      logic [1:0]  spare;
      match_mode_e mode;
      logic        x;
      logic        w;
      logic        r;
   } entry_cfg_t;

endpackage

// File: rtl/mgc_region_match.sv
module mgc_region_match
   import mgc_pkg::*;
#(
   parameter int WA_W = 30
) (
   input  match_mode_e     mode,
   input  logic [WA_W-1:0] word_addr,
   input  logic [WA_W-1:0] own_reg,
   input  logic [WA_W-1:0] prev_reg,
   output logic            hit
);

   logic [WA_W-1:0] napot_mask;

   // ones over the trailing-one run and the zero above it
   assign napot_mask = own_reg ^ (own_reg + {{(WA_W-1){1'b0}}, 1'b1});

   always_comb begin
      unique case (mode)
         MODE_TOR:   hit = (word_addr >= prev_reg) && (word_addr < own_reg);
         MODE_NA4:   hit = (word_addr == own_reg);
         MODE_NAPOT: hit = ((word_addr ^ own_reg) & ~napot_mask) == '0;
         default:    hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/mgc_first_hit.sv
module mgc_first_hit #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     hits,
   output logic             hit_any,
   output logic [IDX_W-1:0] hit_idx
);

   always_comb begin
      hit_idx = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (hits[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit_any = |hits;

endmodule

// File: rtl/mgc_verdict.sv
module mgc_verdict
   import mgc_pkg::*;
(
   input  logic       any_active,
   input  logic       hit_any,
   input  logic       eff_machine,
   input  entry_cfg_t sel_cfg,
   input  logic [1:0] kind,
   output logic       allow,
   output logic [1:0] fault_code
);

   logic perm_ok;
   logic unused_spare;

   assign unused_spare = ^sel_cfg.spare;

   always_comb begin
      unique case (kind)
         KIND_READ:  perm_ok = sel_cfg.r;
         KIND_WRITE: perm_ok = sel_cfg.w;
         default:    perm_ok = sel_cfg.x;
      endcase
   end

   always_comb begin
      if (!any_active)
         allow = 1'b1;
      else if (hit_any)
         allow = (eff_machine && !sel_cfg.locked) || perm_ok;
      else
         allow = eff_machine;
   end

   always_comb begin
      if (allow)
         fault_code = 2'd0;
      else if (kind == KIND_RSVD)
         fault_code = 2'd3;
      else
         fault_code = kind + 2'd1;
   end

endmodule

// File: rtl/mem_guard_checker.sv
module mem_guard_checker
   import mgc_pkg::*;
#(
   parameter int N_REGIONS = 8,
   parameter int ADDR_W    = 32,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [1:0]                    req_kind,
   input  logic [1:0]                    cur_priv,
   input  logic                          mprv_en,
   input  logic [1:0]                    mpp_priv,
   input  logic [8*N_REGIONS-1:0]        region_cfg,
   input  logic [(ADDR_W-2)*N_REGIONS-1:0] region_addr,
   output logic                          rsp_valid,
   output logic                          rsp_allow,
   output logic [1:0]                    rsp_fault
);

   localparam int WA_W  = ADDR_W - 2;
   localparam int IDX_W = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1;

   if (N_REGIONS < 1 || N_REGIONS > 64) begin : g_bad_regions
      $error("N_REGIONS must lie in 1..64");
   end
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
      $error("ADDR_W must lie in 8..64");
   end

   entry_cfg_t           cfg_arr  [N_REGIONS];
   logic [WA_W-1:0]      areg_arr [N_REGIONS];
   logic [N_REGIONS-1:0] match_vec;
   logic [N_REGIONS-1:0] active_vec;
   logic [WA_W-1:0]      word_addr;
   logic [1:0]           eff_priv;
   logic                 eff_machine;
   logic                 any_active;
   logic                 hit_any;
   logic [IDX_W-1:0]     hit_idx;
   entry_cfg_t           sel_cfg;
   logic                 allow_c;
   logic [1:0]           fault_c;
   logic                 unused_low_addr;

   assign word_addr       = req_addr[ADDR_W-1:2];
   assign unused_low_addr = ^req_addr[1:0];

   for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
      logic [WA_W-1:0] prev_reg;

      assign cfg_arr[g]    = entry_cfg_t'(region_cfg[g*8 +: 8]);
      assign areg_arr[g]   = region_addr[g*WA_W +: WA_W];
      assign active_vec[g] = (cfg_arr[g].mode != MODE_OFF);

      if (g == 0) begin : g_first
         assign prev_reg = '0;
      end else begin : g_rest
         assign prev_reg = areg_arr[g-1];
      end

      mgc_region_match #(
         .WA_W(WA_W)
      ) u_match (
         .mode      (cfg_arr[g].mode),
         .word_addr (word_addr),
         .own_reg   (areg_arr[g]),
         .prev_reg  (prev_reg),
         .hit       (match_vec[g])
      );
   end

   // reads and writes take the previous privilege when modify-privilege is on
   assign eff_priv    = (mprv_en && (req_kind != KIND_EXEC) && (req_kind != KIND_RSVD))
                        ? mpp_priv : cur_priv;
   assign eff_machine = (eff_priv == PRIV_MACHINE);
   assign any_active  = |active_vec;

   mgc_first_hit #(
      .N     (N_REGIONS),
      .IDX_W (IDX_W)
   ) u_pick (
      .hits    (match_vec),
      .hit_any (hit_any),
      .hit_idx (hit_idx)
   );

   assign sel_cfg = cfg_arr[hit_idx];

   mgc_verdict u_verdict (
      .any_active  (any_active),
      .hit_any     (hit_any),
      .eff_machine (eff_machine),
      .sel_cfg     (sel_cfg),
      .kind        (req_kind),
      .allow       (allow_c),
      .fault_code  (fault_c)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
            rsp_fault <= 2'd0;
         end else begin
            rsp_valid <= req_valid;
            rsp_allow <= allow_c;
            rsp_fault <= fault_c;
         end
      end

      // R11
      valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (rsp_valid == $past(req_valid)));
   end else begin : g_comb_out
      assign rsp_valid = req_valid;
      assign rsp_allow = allow_c;
      assign rsp_fault = fault_c;
   end

   // checker-side view of regions numbered below the chosen one
   logic [N_REGIONS-1:0] below_pick;
   always_comb begin
      for (int i = 0; i < N_REGIONS; i++) begin
         below_pick[i] = (i < int'(hit_idx));
      end
   end

   // R2
   pick_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_any |-> match_vec[hit_idx]);

   // R2
   pick_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_any |-> ((match_vec & below_pick) == '0));

   // R1
   idle_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_active |-> allow_c);

   // R6
   mach_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_machine && hit_any && !sel_cfg.locked) |-> allow_c);

   // R8
   miss_low_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_active && !hit_any && !eff_machine) |-> (!allow_c && (fault_c != 2'd0)));

   // R10
   allow_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      allow_c |-> (fault_c == 2'd0));

endmodule

// File: tb/test_mem_guard_checker.sv
`timescale 1ns/1ps
module test_mem_guard_checker;

   localparam int NR   = 8;
   localparam int AW   = 32;
   localparam int WAW  = AW - 2;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req_valid = 1'b0;
   logic [AW-1:0]       req_addr = '0;
   logic [1:0]          req_kind = '0;
   logic [1:0]          cur_priv = '0;
   logic                mprv_en = 1'b0;
   logic [1:0]          mpp_priv = '0;
   logic [8*NR-1:0]     region_cfg = '0;
   logic [WAW*NR-1:0]   region_addr = '0;
   logic                rsp_valid;
   logic                rsp_allow;
   logic [1:0]          rsp_fault;

   always #5 clk = ~clk;

   mem_guard_checker #(.N_REGIONS(NR), .ADDR_W(AW), .REG_OUT(1'b1)) i_mem_guard_checker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_kind(req_kind), .cur_priv(cur_priv), .mprv_en(mprv_en), .mpp_priv(mpp_priv),
      .region_cfg(region_cfg), .region_addr(region_addr),
      .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   bit [7:0]          cfg_b [NR];
   longint unsigned   areg  [NR];

   bit     exp_valid;
   bit     exp_allow;
   int     exp_fault;
   string  exp_tag;

   function automatic bit covers(int i, longint unsigned a);
      int mode = (cfg_b[i] >> 3) & 3;
      longint unsigned lo, hi, size;
      int t;
      case (mode)
         1: begin
            lo = (i == 0) ? 0 : areg[i-1] * 4;
            hi = areg[i] * 4;
            return (a >= lo) && (a < hi);
         end
         2: return (a >= areg[i] * 4) && (a < areg[i] * 4 + 4);
         3: begin
            t = 0;
            while (t < WAW && areg[i][t]) t++;
            size = longint'(1) << (t + 3);
            lo = (areg[i] * 4) & ~(size - 1);
            return (a >= lo) && (a < lo + size);
         end
         default: return 0;
      endcase
   endfunction

   task automatic ref_eval(input longint unsigned a, input int kind, input int priv,
                           input bit mprv, input int mpp, output bit allow, output int fcode);
      int  ep;
      bit  mach, active;
      int  found;
      ep = (mprv && kind != 2) ? mpp : priv;
      mach = (ep == 3);
      active = 0;
      found = -1;
      for (int i = 0; i < NR; i++) if (((cfg_b[i] >> 3) & 3) != 0) active = 1;
      for (int i = 0; i < NR; i++) if (found < 0 && covers(i, a)) found = i;
      if (!active) allow = 1;
      else if (found >= 0) allow = (mach && !cfg_b[found][7]) || cfg_b[found][kind];
      else allow = mach;
      fcode = allow ? 0 : kind + 1;
   endtask

   task automatic push_table();
      for (int i = 0; i < NR; i++) begin
         region_cfg[i*8 +: 8]      = cfg_b[i];
         region_addr[i*WAW +: WAW] = areg[i][WAW-1:0];
      end
   endtask

   task automatic compare_now();
      checks++;
      if (rsp_valid !== exp_valid || rsp_allow !== exp_allow || int'(rsp_fault) != exp_fault) begin
         errors++;
         $display("FAIL %s actual valid=%0b allow=%0b fault=%0d expected valid=%0b allow=%0b fault=%0d",
                  exp_tag, rsp_valid, rsp_allow, rsp_fault, exp_valid, exp_allow, exp_fault);
      end
   endtask

   task automatic apply(input bit v, input longint unsigned a, input int kind, input int priv,
                        input bit mprv, input int mpp, input string tag);
      bit al;
      int fc;
      @(negedge clk);
      compare_now();
      req_valid = v;
      req_addr  = a[AW-1:0];
      req_kind  = kind[1:0];
      cur_priv  = priv[1:0];
      mprv_en   = mprv;
      mpp_priv  = mpp[1:0];
      push_table();
      ref_eval(a, kind, priv, mprv, mpp, al, fc);
      exp_valid = v;
      exp_allow = al;
      exp_fault = fc;
      exp_tag   = tag;
   endtask

   task automatic random_burst(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         int p = $urandom_range(0, 2);
         apply($urandom_range(0, 1), longint'($urandom_range(0, 'h1FFFF)), $urandom_range(0, 2),
               (p == 2) ? 3 : p, $urandom_range(0, 1), ($urandom_range(0, 1) == 1) ? 3 : 0, tag);
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) begin cfg_b[i] = 8'h00; areg[i] = 0; end
      // reset state
      repeat (3) @(negedge clk);
      exp_valid = 0; exp_allow = 0; exp_fault = 0; exp_tag = "R11 reset";
      compare_now();
      rst_n = 1'b1;
      push_table();
      begin
         bit al; int fc;
         ref_eval(0, 0, 0, 0, 0, al, fc);
         exp_valid = 0; exp_allow = al; exp_fault = fc; exp_tag = "R1 after reset";
      end

      // empty table: all allowed
      apply(1, 'h1234, 0, 0, 0, 0, "R1");
      apply(1, 'h8000, 1, 1, 0, 0, "R1");
      apply(1, 'hFFF0, 2, 0, 0, 0, "R1");

      // program regions
      cfg_b[0] = 8'h09; areg[0] = 'h400;   // top of range 0..0x1000, read
      cfg_b[1] = 8'h1B; areg[1] = 'h81F;   // NAPOT 0x2000 size 256, read/write
      cfg_b[2] = 8'h14; areg[2] = 'hC00;   // 4-byte at 0x3000, fetch
      cfg_b[3] = 8'h0F; areg[3] = 'h1000;  // top of range 0x3000..0x4000, all
      cfg_b[4] = 8'h1F; areg[4] = 'h1FFF;  // NAPOT 0..0x10000, all

      apply(1, 'h0800, 0, 0, 0, 0, "R3");
      apply(1, 'h0800, 1, 0, 0, 0, "R2");
      apply(1, 'h0FFC, 1, 0, 0, 0, "R3");
      apply(1, 'h1000, 1, 0, 0, 0, "R3");
      apply(1, 'h2010, 1, 1, 0, 0, "R4");
      apply(1, 'h20FC, 2, 0, 0, 0, "R4");
      apply(1, 'h3000, 2, 0, 0, 0, "R4");
      apply(1, 'h3000, 0, 0, 0, 0, "R2");
      apply(1, 'h3004, 2, 0, 0, 0, "R3");
      apply(1, 'h20000, 0, 0, 0, 0, "R8");
      apply(1, 'h20000, 2, 1, 0, 0, "R10");
      apply(1, 'h20000, 0, 3, 0, 0, "R8");
      apply(1, 'h0800, 1, 3, 0, 0, "R6");
      apply(1, 'h3000, 1, 3, 0, 0, "R6");

      // lock region 0
      cfg_b[0] = 8'h89;
      apply(1, 'h0800, 1, 3, 0, 0, "R7");
      apply(1, 'h0800, 0, 3, 0, 0, "R7");
      apply(1, 'h0800, 2, 3, 0, 0, "R7");

      // modify-privilege
      apply(1, 'h20000, 0, 3, 1, 0, "R9");
      apply(1, 'h20000, 1, 3, 1, 0, "R9");
      apply(1, 'h20000, 2, 3, 1, 0, "R9");
      apply(1, 'h20000, 0, 3, 1, 3, "R9");
      apply(1, 'h0800, 0, 0, 1, 3, "R9");
      apply(0, 'h0800, 1, 0, 0, 0, "R11");

      random_burst(300, "R5");

      // lock several regions, then random again
      cfg_b[1] = 8'h9B; cfg_b[3] = 8'h8F; cfg_b[2] = 8'h94;
      random_burst(300, "R7");

      // all off again
      for (int i = 0; i < NR; i++) cfg_b[i] = 8'h00;
      random_burst(40, "R1");

      apply(0, 0, 0, 0, 0, 0, "R11");
      @(negedge clk);
      compare_now();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule